// File: doc/BRIEF.md
# Register Rename Unit with Reorder Buffer

This unit maps a small set of architectural registers onto a larger shared pool of physical registers. It also keeps the instructions that are in flight in program order. A map table gives the current physical tag of each architectural register, together with a ready flag. A first-in first-out free list holds the physical tags that are not in use. A circular reorder buffer (ROB) holds one entry per dispatched instruction. Each ROB entry stores the tag that was newly allocated to the instruction and the tag that its destination mapped to before.

The unit accepts at most one decoded instruction per cycle. The instruction has two source register indices and an optional destination register index. One cycle later the unit returns:
- the physical tags of both sources, with their ready flags;
- the newly allocated destination tag;
- the ROB slot given to the instruction.

The execution side reports two kinds of event by ROB slot. An issue report marks the instruction as started. A completion report marks it as finished, and it can carry a result tag that wakes up the map table. Each cycle the oldest instruction retires if it has completed. On retirement, its previous destination tag is handed back to the free list.

Top module: `rename_rob_unit`

## Requirements
- R1: After reset, architectural register i (0 to 3 are f0 to f3, 4 to 7 are r1 to r4) maps to physical tag i+1, and every mapping is ready.
- R2: After reset, the free list holds tags 9 to 16 and hands them out in that order. A tag freed by retirement joins the back of the list. Tag value 0 means "no tag".
- R3: An accepted instruction gets its source tags from the map table as it stood before the instruction's own destination is written. Its ROB slot is the tail slot, and slots are given out in sequence 0 to 7, wrapping around.
- R4: An accepted instruction with a destination maps that register to the new tag with ready clear. A later instruction reading the register sees ready 0 until the tag is broadcast.
- R5: A completion that is accepted and carries a tag sets the ready flag of every register whose current mapping equals that tag. A source read in the same cycle sees ready 1.
- R6: `disp_stall` is high when all 8 ROB entries are occupied, or when the instruction needs a destination and the free list is empty. A stalled instruction has no effect.
- R7: A completion report for a slot that is empty or not yet issued is ignored. That entry does not retire, and no ready flag changes.
- R8: Retirement is in program order, at most one per cycle, and only when the head entry is complete. `ret_valid` and its fields appear one cycle after the retiring edge.
- R9: An instruction with no destination returns destination tag 0, and it neither takes nor gives back a tag. On retirement it reports `ret_has_dst` 0, and on retirement an instruction with a destination reports its new tag and its previous tag.
- R10: The response to an accepted instruction appears in the cycle after acceptance, and `rsp_valid` is low after any cycle that accepted nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_src1 | input | 3 | First source architectural register |
| disp_src2 | input | 3 | Second source architectural register |
| disp_has_dst | input | 1 | Instruction writes a destination |
| disp_dst | input | 3 | Destination architectural register |
| disp_stall | output | 1 | Dispatch refused this cycle |
| rsp_valid | output | 1 | Rename response valid |
| rsp_src1_tag | output | 5 | Physical tag of first source |
| rsp_src1_rdy | output | 1 | First source value available |
| rsp_src2_tag | output | 5 | Physical tag of second source |
| rsp_src2_rdy | output | 1 | Second source value available |
| rsp_dst_tag | output | 5 | Allocated destination tag, 0 if none |
| rsp_rob_idx | output | 3 | ROB slot of the instruction |
| iss_valid | input | 1 | Issue report |
| iss_rob_idx | input | 3 | Slot being issued |
| cdb_valid | input | 1 | Completion report |
| cdb_rob_idx | input | 3 | Slot completing |
| cdb_has_tag | input | 1 | Completion carries a result tag |
| cdb_tag | input | 5 | Result tag broadcast |
| ret_valid | output | 1 | An instruction retired |
| ret_rob_idx | output | 3 | Slot retired |
| ret_has_dst | output | 1 | Retired instruction had a destination |
| ret_tag | output | 5 | Its allocated tag |
| ret_told | output | 5 | Its previous tag, now freed |

## Verification
The assertions rely on the execution side behaving sensibly:
- it issues only occupied slots that have not been issued yet;
- a completion carries exactly the tag that was allocated to that slot, and it carries one only when the slot has a destination.

Under these assumptions the free list can never overflow and a newly written mapping stays not ready until its broadcast. The bench keeps a model of slot occupancy and picks issue and completion targets from that model. The one deliberate exception is completion reports aimed at slots that are empty or not yet issued, because ignoring those is itself a requirement.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  localparam int ARCH_REGS   = 8;
  localparam int PHYS_REGS   = 16;
  localparam int ROB_ENTRIES = 8;
  // tag 0 is reserved for "no tag", so tags run 1..PHYS_REGS
  localparam int TAG_BITS    = $clog2(PHYS_REGS + 1);
  localparam int ARCH_BITS   = $clog2(ARCH_REGS);
  localparam int ROB_BITS    = $clog2(ROB_ENTRIES);
endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
  parameter int NUM_ARCH = rnm_pkg::ARCH_REGS,
  parameter int TAG_W    = rnm_pkg::TAG_BITS,
  localparam int ARCH_W  = $clog2(NUM_ARCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ARCH_W-1:0] rd1_arch,
  output logic [TAG_W-1:0]  rd1_tag,
  output logic              rd1_rdy,
  input  logic [ARCH_W-1:0] rd2_arch,
  output logic [TAG_W-1:0]  rd2_tag,
  output logic              rd2_rdy,
  input  logic [ARCH_W-1:0] rdd_arch,
  output logic [TAG_W-1:0]  rdd_tag,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_arch,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              bc_en,
  input  logic [TAG_W-1:0]  bc_tag
);
  logic [TAG_W-1:0]    map_q [NUM_ARCH];
  logic [NUM_ARCH-1:0] rdy_q;

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        map_q[g] <= TAG_W'(g + 1);
        rdy_q[g] <= 1'b1;
      end else if (wr_en && wr_arch == ARCH_W'(g)) begin
        map_q[g] <= wr_tag;
        rdy_q[g] <= 1'b0;
      end else if (bc_en && map_q[g] == bc_tag) begin
        rdy_q[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd1_tag = map_q[rd1_arch];
    rd2_tag = map_q[rd2_arch];
    rdd_tag = map_q[rdd_arch];
    rd1_rdy = rdy_q[rd1_arch] | (bc_en && map_q[rd1_arch] == bc_tag);
    rd2_rdy = rdy_q[rd2_arch] | (bc_en && map_q[rd2_arch] == bc_tag);
  end

  AST_MAP_NEW_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !rdy_q[$past(wr_arch)]) else $error("new mapping marked ready"); // R4
endmodule

// File: rtl/rnm_free_list.sv
module rnm_free_list #(
  parameter int DEPTH     = rnm_pkg::PHYS_REGS - rnm_pkg::ARCH_REGS,
  parameter int FIRST_TAG = rnm_pkg::ARCH_REGS + 1,
  parameter int TAG_W     = rnm_pkg::TAG_BITS,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  output logic [TAG_W-1:0] head_tag,
  output logic             empty,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag
);
  logic [TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= TAG_W'(FIRST_TAG + i);
    end else if (push) begin
      mem[wr_ptr] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= CNT_W'(DEPTH);
    end else begin
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push) wr_ptr <= bump(wr_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_tag = mem[rd_ptr];
  assign empty    = (count == '0);

  AST_FL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0) else $error("free list underflow"); // R6
  AST_FL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> count != CNT_W'(DEPTH)) else $error("free list overflow"); // R2
endmodule

// File: rtl/rnm_rob.sv
module rnm_rob #(
  parameter int DEPTH  = rnm_pkg::ROB_ENTRIES,
  parameter int TAG_W  = rnm_pkg::TAG_BITS,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             alloc_has_dst,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic [TAG_W-1:0] alloc_told,
  output logic [IDX_W-1:0] alloc_idx,
  output logic             full,
  input  logic             iss_en,
  input  logic [IDX_W-1:0] iss_idx,
  input  logic             cmp_req,
  input  logic [IDX_W-1:0] cmp_idx,
  output logic             cmp_ok,
  output logic             ret_fire,
  output logic [IDX_W-1:0] ret_idx,
  output logic             ret_has_dst,
  output logic [TAG_W-1:0] ret_tag,
  output logic [TAG_W-1:0] ret_told
);
  logic [DEPTH-1:0] vld_q, iss_q, done_q;
  logic [DEPTH-1:0] hd_mem;
  logic [TAG_W-1:0] tag_mem  [DEPTH];
  logic [TAG_W-1:0] told_mem [DEPTH];
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign alloc_idx = tail;
  assign cmp_ok    = cmp_req && vld_q[cmp_idx] && iss_q[cmp_idx];
  assign ret_fire  = vld_q[head] && done_q[head];
  assign ret_idx   = head;
  assign ret_has_dst = hd_mem[head];
  assign ret_tag   = tag_mem[head];
  assign ret_told  = told_mem[head];

  // status flags per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g]  <= 1'b0;
        iss_q[g]  <= 1'b0;
        done_q[g] <= 1'b0;
      end else if (alloc && tail == IDX_W'(g)) begin
        vld_q[g]  <= 1'b1;
        iss_q[g]  <= 1'b0;
        done_q[g] <= 1'b0;
      end else begin
        if (ret_fire && head == IDX_W'(g)) vld_q[g] <= 1'b0;
        if (iss_en && iss_idx == IDX_W'(g)) iss_q[g] <= 1'b1;
        if (cmp_ok && cmp_idx == IDX_W'(g)) done_q[g] <= 1'b1;
      end
    end
  end

  // payload: written once at allocation, no reset needed
  always_ff @(posedge clk) begin
    if (alloc) begin
      hd_mem[tail]   <= alloc_has_dst;
      tag_mem[tail]  <= alloc_tag;
      told_mem[tail] <= alloc_told;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (ret_fire) head <= bump(head);
      if (alloc)    tail <= bump(tail);
      case ({alloc, ret_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_ROB_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !full) else $error("allocation into full ROB"); // R6
  AST_ROB_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    ret_fire |=> head == (($past(head) == IDX_W'(DEPTH - 1)) ? '0 : $past(head) + 1'b1))
    else $error("head did not advance by one"); // R8
  AST_ROB_CMP_MARKS: assert property (@(posedge clk) disable iff (rst)
    cmp_ok |=> done_q[$past(cmp_idx)]) else $error("accepted completion lost"); // R7
endmodule

// File: rtl/rename_rob_unit.sv
module rename_rob_unit #(
  parameter int NUM_ARCH = rnm_pkg::ARCH_REGS,
  parameter int NUM_PHYS = rnm_pkg::PHYS_REGS,
  parameter int ROB_SIZE = rnm_pkg::ROB_ENTRIES,
  localparam int TAG_W   = $clog2(NUM_PHYS + 1),
  localparam int ARCH_W  = $clog2(NUM_ARCH),
  localparam int IDX_W   = $clog2(ROB_SIZE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_valid,
  input  logic [ARCH_W-1:0] disp_src1,
  input  logic [ARCH_W-1:0] disp_src2,
  input  logic              disp_has_dst,
  input  logic [ARCH_W-1:0] disp_dst,
  output logic              disp_stall,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_src1_tag,
  output logic              rsp_src1_rdy,
  output logic [TAG_W-1:0]  rsp_src2_tag,
  output logic              rsp_src2_rdy,
  output logic [TAG_W-1:0]  rsp_dst_tag,
  output logic [IDX_W-1:0]  rsp_rob_idx,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_rob_idx,
  input  logic              cdb_valid,
  input  logic [IDX_W-1:0]  cdb_rob_idx,
  input  logic              cdb_has_tag,
  input  logic [TAG_W-1:0]  cdb_tag,
  output logic              ret_valid,
  output logic [IDX_W-1:0]  ret_rob_idx,
  output logic              ret_has_dst,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [TAG_W-1:0]  ret_told
);
  localparam int FREE_DEPTH = NUM_PHYS - NUM_ARCH;

  logic             accept, take_tag;
  logic             fl_empty, fl_push;
  logic [TAG_W-1:0] fl_head;
  logic             rob_full, cmp_ok, bc_en;
  logic [IDX_W-1:0] rob_tail;
  logic [TAG_W-1:0] s1_tag, s2_tag, old_tag;
  logic             s1_rdy, s2_rdy;
  logic             r_fire, r_hd;
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag, r_told;

  assign disp_stall = rob_full || (disp_has_dst && fl_empty);
  assign accept     = disp_valid && !disp_stall;
  assign take_tag   = accept && disp_has_dst;
  assign bc_en      = cmp_ok && cdb_has_tag;
  assign fl_push    = r_fire && r_hd;

  rnm_map_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) u_map (
    .clk(clk), .rst(rst),
    .rd1_arch(disp_src1), .rd1_tag(s1_tag), .rd1_rdy(s1_rdy),
    .rd2_arch(disp_src2), .rd2_tag(s2_tag), .rd2_rdy(s2_rdy),
    .rdd_arch(disp_dst),  .rdd_tag(old_tag),
    .wr_en(take_tag), .wr_arch(disp_dst), .wr_tag(fl_head),
    .bc_en(bc_en), .bc_tag(cdb_tag)
  );

  rnm_free_list #(.DEPTH(FREE_DEPTH), .FIRST_TAG(NUM_ARCH + 1), .TAG_W(TAG_W)) u_free (
    .clk(clk), .rst(rst),
    .pop(take_tag), .head_tag(fl_head), .empty(fl_empty),
    .push(fl_push), .push_tag(r_told)
  );

  rnm_rob #(.DEPTH(ROB_SIZE), .TAG_W(TAG_W)) u_rob (
    .clk(clk), .rst(rst),
    .alloc(accept), .alloc_has_dst(disp_has_dst),
    .alloc_tag(fl_head), .alloc_told(old_tag),
    .alloc_idx(rob_tail), .full(rob_full),
    .iss_en(iss_valid), .iss_idx(iss_rob_idx),
    .cmp_req(cdb_valid), .cmp_idx(cdb_rob_idx), .cmp_ok(cmp_ok),
    .ret_fire(r_fire), .ret_idx(r_idx), .ret_has_dst(r_hd),
    .ret_tag(r_tag), .ret_told(r_told)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      ret_valid <= 1'b0;
    end else begin
      rsp_valid <= accept;
      ret_valid <= r_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rsp_src1_tag <= s1_tag;
      rsp_src1_rdy <= s1_rdy;
      rsp_src2_tag <= s2_tag;
      rsp_src2_rdy <= s2_rdy;
      rsp_dst_tag  <= disp_has_dst ? fl_head : '0;
      rsp_rob_idx  <= rob_tail;
    end
    if (r_fire) begin
      ret_rob_idx <= r_idx;
      ret_has_dst <= r_hd;
      ret_tag     <= r_hd ? r_tag : '0;
      ret_told    <= r_hd ? r_told : '0;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_stall) |=> rsp_valid) else $error("response missing"); // R10
  AST_RSP_DST_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_stall && disp_has_dst) |=> rsp_dst_tag != '0)
    else $error("destination got no tag"); // R9
endmodule

// File: tb/rename_rob_unit_bench.sv
module rename_rob_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid = 1'b0, disp_has_dst = 1'b0;
  logic [2:0] disp_src1 = '0, disp_src2 = '0, disp_dst = '0;
  logic disp_stall, rsp_valid, rsp_src1_rdy, rsp_src2_rdy;
  logic [4:0] rsp_src1_tag, rsp_src2_tag, rsp_dst_tag;
  logic [2:0] rsp_rob_idx;
  logic iss_valid = 1'b0, cdb_valid = 1'b0, cdb_has_tag = 1'b0;
  logic [2:0] iss_rob_idx = '0, cdb_rob_idx = '0;
  logic [4:0] cdb_tag = '0;
  logic ret_valid, ret_has_dst;
  logic [2:0] ret_rob_idx;
  logic [4:0] ret_tag, ret_told;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_rob_unit u_rename_rob_unit (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_src1(disp_src1), .disp_src2(disp_src2),
    .disp_has_dst(disp_has_dst), .disp_dst(disp_dst), .disp_stall(disp_stall),
    .rsp_valid(rsp_valid), .rsp_src1_tag(rsp_src1_tag), .rsp_src1_rdy(rsp_src1_rdy),
    .rsp_src2_tag(rsp_src2_tag), .rsp_src2_rdy(rsp_src2_rdy),
    .rsp_dst_tag(rsp_dst_tag), .rsp_rob_idx(rsp_rob_idx),
    .iss_valid(iss_valid), .iss_rob_idx(iss_rob_idx),
    .cdb_valid(cdb_valid), .cdb_rob_idx(cdb_rob_idx),
    .cdb_has_tag(cdb_has_tag), .cdb_tag(cdb_tag),
    .ret_valid(ret_valid), .ret_rob_idx(ret_rob_idx), .ret_has_dst(ret_has_dst),
    .ret_tag(ret_tag), .ret_told(ret_told)
  );

  // reference model
  int m_map[NA];
  bit m_rdy[NA];
  int fq[$];
  bit m_v[NR], m_hd[NR], m_is[NR], m_dn[NR];
  int m_tg[NR], m_to[NR];
  int m_head, m_tail, m_cnt;

  // expected registered outputs
  bit e_rsp_v, e_r1, e_r2, e_ret_v, e_ret_hd;
  int e_s1, e_s2, e_dst, e_idx, e_ret_idx, e_ret_tg, e_ret_to;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) begin m_map[i] = i + 1; m_rdy[i] = 1; end
    fq.delete();
    for (int i = 0; i < 8; i++) fq.push_back(9 + i);
    for (int i = 0; i < NR; i++) begin m_v[i] = 0; m_is[i] = 0; m_dn[i] = 0; end
    m_head = 0; m_tail = 0; m_cnt = 0;
  endtask

  function automatic bit exp_stall(input bit hd);
    return (m_cnt == NR) || (hd && fq.size() == 0);
  endfunction

  // called just after a falling edge; returns just after the next falling edge
  task automatic do_cycle(input bit dv, input int s1, input int s2, input bit hd, input int d,
                          input bit iv, input int ii, input bit cv, input int ci);
    bit acc, cok, bc, ret;
    int bct, newt;
    disp_valid = dv; disp_src1 = 3'(s1); disp_src2 = 3'(s2);
    disp_has_dst = hd; disp_dst = 3'(d);
    iss_valid = iv; iss_rob_idx = 3'(ii);
    cdb_valid = cv; cdb_rob_idx = 3'(ci);
    cdb_has_tag = m_v[ci] && m_hd[ci];
    cdb_tag = cdb_has_tag ? 5'(m_tg[ci]) : 5'd0;
    #1;
    chk("R6", "disp_stall", int'(disp_stall), int'(exp_stall(hd)));
    acc = dv && !exp_stall(hd);
    cok = cv && m_v[ci] && m_is[ci];
    bc  = cok && m_hd[ci];
    bct = m_tg[ci];
    ret = m_v[m_head] && m_dn[m_head];
    newt = (acc && hd) ? fq[0] : 0;
    e_rsp_v = acc;
    if (acc) begin
      e_s1 = m_map[s1]; e_r1 = m_rdy[s1] || (bc && bct == m_map[s1]);
      e_s2 = m_map[s2]; e_r2 = m_rdy[s2] || (bc && bct == m_map[s2]);
      e_dst = newt; e_idx = m_tail;
    end
    e_ret_v = ret;
    if (ret) begin
      e_ret_idx = m_head; e_ret_hd = m_hd[m_head];
      e_ret_tg = m_hd[m_head] ? m_tg[m_head] : 0;
      e_ret_to = m_hd[m_head] ? m_to[m_head] : 0;
    end
    // state update
    if (ret) begin
      m_v[m_head] = 0;
      if (m_hd[m_head]) fq.push_back(m_to[m_head]);
      m_head = (m_head + 1) % NR;
      m_cnt--;
    end
    if (iv) m_is[ii] = 1;
    if (cok) m_dn[ci] = 1;
    if (acc) begin
      m_v[m_tail] = 1; m_is[m_tail] = 0; m_dn[m_tail] = 0; m_hd[m_tail] = hd;
      m_tg[m_tail] = newt; m_to[m_tail] = hd ? m_map[d] : 0;
      m_tail = (m_tail + 1) % NR;
      m_cnt++;
    end
    for (int i = 0; i < NA; i++) begin
      if (acc && hd && d == i) begin m_map[i] = newt; m_rdy[i] = 0; end
      else if (bc && m_map[i] == bct) m_rdy[i] = 1;
    end
    if (acc && hd) void'(fq.pop_front());
    @(posedge clk);
    @(negedge clk);
    chk("R10", "rsp_valid", int'(rsp_valid), int'(e_rsp_v));
    if (e_rsp_v && rsp_valid) begin
      chk("R3", "src1 tag", int'(rsp_src1_tag), e_s1);
      chk("R3", "src2 tag", int'(rsp_src2_tag), e_s2);
      chk("R5", "src1 ready", int'(rsp_src1_rdy), int'(e_r1));
      chk("R5", "src2 ready", int'(rsp_src2_rdy), int'(e_r2));
      chk("R2", "dst tag", int'(rsp_dst_tag), e_dst);
      chk("R3", "rob idx", int'(rsp_rob_idx), e_idx);
    end
    chk("R8", "ret_valid", int'(ret_valid), int'(e_ret_v));
    if (e_ret_v && ret_valid) begin
      chk("R8", "ret idx", int'(ret_rob_idx), e_ret_idx);
      chk("R9", "ret has dst", int'(ret_has_dst), int'(e_ret_hd));
      chk("R9", "ret tag", int'(ret_tag), e_ret_tg);
      chk("R2", "ret told", int'(ret_told), e_ret_to);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed, slot;
    seed = $urandom(32'h5eed_0042);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    disp_has_dst = 1'b1;
    #1;
    chk("R6", "stall after reset", int'(disp_stall), 0);
    chk("R10", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R8", "ret_valid after reset", int'(ret_valid), 0);

    // R1: read every reset mapping, no destinations, fills the ROB
    for (int i = 0; i < NA; i++) begin
      do_cycle(1, i, (i + 1) % NA, 0, 0, 0, 0, 0, 0);
      chk("R1", "reset map tag", int'(rsp_src1_tag), i + 1);
      chk("R1", "reset map ready", int'(rsp_src1_rdy), 1);
      chk("R9", "no-dst tag", int'(rsp_dst_tag), 0);
    end
    // R6: ROB full refuses dispatch
    do_cycle(1, 0, 1, 1, 2, 0, 0, 0, 0);
    chk("R6", "stalled dispatch ignored", int'(rsp_valid), 0);
    for (int i = 0; i < NR; i++) do_cycle(0, 0, 0, 0, 0, 1, i, 0, 0);
    for (int i = 0; i < NR; i++) do_cycle(0, 0, 0, 0, 0, 0, 0, 1, i);
    idle(2);

    // R4 and R7: new mapping not ready, completion without issue ignored
    slot = m_tail;
    do_cycle(1, 1, 2, 1, 0, 0, 0, 0, 0);
    chk("R2", "first allocated tag", int'(rsp_dst_tag), 9);
    do_cycle(1, 0, 3, 0, 0, 0, 0, 0, 0);
    chk("R4", "renamed source not ready", int'(rsp_src1_rdy), 0);
    do_cycle(0, 0, 0, 0, 0, 0, 0, 1, slot);
    do_cycle(1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7", "unissued completion gives no retire", int'(ret_valid), 0);
    chk("R7", "unissued completion leaves not ready", int'(rsp_src1_rdy), 0);
    do_cycle(0, 0, 0, 0, 0, 1, slot, 0, 0);
    // R5: same-cycle broadcast forwarded to a reading source
    do_cycle(1, 0, 0, 0, 0, 0, 0, 1, slot);
    chk("R5", "forwarded ready", int'(rsp_src1_rdy), 1);
    chk("R5", "forwarded tag", int'(rsp_src1_tag), 9);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit dv, hd, iv, cv;
      int ii, ci, r;
      dv = ($urandom % 4) != 0;
      hd = ($urandom % 4) != 0;
      iv = 0; ii = 0; cv = 0; ci = 0;
      r = $urandom % NR;
      if (m_v[r] && !m_is[r] && ($urandom % 2)) begin iv = 1; ii = r; end
      r = $urandom % NR;
      if (m_v[r] && m_is[r] && !m_dn[r]) begin cv = 1; ci = r; end
      else if (($urandom % 16) == 0) begin cv = 1; ci = r; end
      do_cycle(dv, $urandom % NA, $urandom % NA, hd, $urandom % NA, iv, ii, cv, ci);
    end
    // drain
    for (int n = 0; n < 3; n++) begin
      for (int i = 0; i < NR; i++)
        if (m_v[i] && !m_is[i]) do_cycle(0, 0, 0, 0, 0, 1, i, 0, 0);
      for (int i = 0; i < NR; i++)
        if (m_v[i] && m_is[i] && !m_dn[i]) do_cycle(0, 0, 0, 0, 0, 0, 0, 1, i);
    end
    idle(NR + 2);
    chk("R2", "all tags back on free list", fq.size(), 8);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule